// File: doc/BRIEF.md
# NIC Interrupt Moderation Controller

This block sits between the receive and transmit engines of a network controller and the host interrupt input. Cause pulses from the engines are collected in a sticky cause register, and one level-style interrupt line goes to the host. A throttle keeps a minimum spacing between deliveries. The spacing is programmed in steps of 256 ns and is measured from the time of the last delivered interrupt. A cause that arrives too early is not lost. A single deferred delivery is armed, and it fires as soon as the spacing has elapsed. Causes marked urgent bypass the throttle.

The receive side has two delay timers, counted in a fixed delay unit (`DLY_UNIT_NS`). Each completed packet restarts the per-packet timer. The absolute timer is started only when it is idle. When either timer expires, it posts the receive-timer cause through the same throttle. When both delays are programmed to zero, every completed packet posts that cause at once.

Software reads the cause register through a read strobe. The strobe returns the current contents and clears the register, which also drops the interrupt line. Time is taken from an internal nanosecond counter that advances by `NS_PER_CLK` each clock. The counter starts at zero at reset, and the last-delivery timestamp also starts at zero.

Top module: `nic_irq_moderator`

## Requirements
- R1: Cause bits on `causeIn`, and the receive-timer cause on bit `RXT_BIT`, are ORed into the cause register at the clock edge. They stay set until they are read. `causeRdData` always shows the register.
- R2: A cycle with `causeRdIn` high clears the cause register at the edge. Bits posted in that same cycle survive the clear.
- R3: `irqOut` is high only after a delivery, and only while at least one cause bit that is enabled in `causeMask` is set. A read drops the line. A cause whose bits are all masked never causes a delivery.
- R4: With a throttle interval of zero, an enabled cause is delivered at the next edge.
- R5: An enabled cause posted together with `urgentIn` is delivered at the next edge, whatever the interval.
- R6: The spacing is `itrInterval` × 256 ns, measured from the last delivery. The timestamp is zero after reset and is updated on every delivery. A cause that arrives when the spacing has already elapsed is delivered at the next edge.
- R7: A cause that arrives too early arms one deferred delivery, which fires in the first cycle where the spacing has elapsed. Later causes do not move it.
- R8: Any delivery cancels a pending deferral. Later early causes are then measured from the new timestamp.
- R9: On a packet completion with `rxAbsDelay` ≠ 0, the absolute timer starts at `rxAbsDelay` units, but only if it is idle. The receive-timer cause appears `rxAbsDelay`×`DLY_UNIT_NS`/`NS_PER_CLK` edges after the completion edge.
- R10: On every packet completion with `rxPktDelay` ≠ 0, the per-packet timer restarts from `rxPktDelay` units, and its expiry posts the receive-timer cause.
- R11: When both delays are zero, a packet completion posts the receive-timer cause at the next edge.
- R12: Causes posted by the timers are never urgent and obey the throttle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| causeIn | input | CAUSE_W | Cause pulses from the engines |
| urgentIn | input | 1 | Marks this cycle's causes for immediate delivery |
| pktDoneIn | input | 1 | Strobe for a completed received packet |
| causeMask | input | CAUSE_W | Enable for each cause bit |
| itrInterval | input | ITR_W | Minimum spacing, in 256 ns steps |
| rxPktDelay | input | DLY_W | Per-packet delay, in delay units |
| rxAbsDelay | input | DLY_W | Absolute delay, in delay units |
| causeRdIn | input | 1 | Read-and-clear strobe |
| causeRdData | output | CAUSE_W | Cause register contents |
| irqOut | output | 1 | Interrupt line to the host |

## Verification
Two cases can fall in the same cycle. In the first, a read-and-clear meets a new cause, which may come from a pulse or a timer expiry. The bench drives these collisions both directly and at random with frequent reads, and it expects the new bits to survive while the old bits go. In the second, a deferred delivery falls due in the same cycle as an urgent or a fresh cause. Directed sequences arm a deferral, then send an urgent cause, and measure that the next delivery is spaced from the urgent one. A cycle-by-cycle reference model in the bench judges both the line and the register on every edge.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic deliver;     // raise the line and stamp the time
    logic clearCause;  // read: replace register with this cycle's posts
    logic dropLine;    // read without a delivery: lower the line
  } irqStrobes_t;
endpackage

// File: rtl/nic_irq_countdown.sv
module nic_irq_countdown #(
  parameter int CNT_W   = 24,
  parameter bit RESTART = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] loadVal,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (startReq && (RESTART || cnt == '0)) cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CNT_W'(1));

  generate
    if (RESTART) begin : g_restart
      AST_PKT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
        startReq |=> cnt == $past(loadVal)); // R10
    end else begin : g_hold
      AST_ABS_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
        startReq && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R9
    end
  endgenerate
endmodule

// File: rtl/nic_irq_rx_timers.sv
module nic_irq_rx_timers #(
  parameter int DLY_W         = 16,
  parameter int CLKS_PER_UNIT = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktDoneIn,
  input  logic [DLY_W-1:0] rxPktDelay,
  input  logic [DLY_W-1:0] rxAbsDelay,
  output logic             rxtPost
);
  localparam int CNT_W = DLY_W + $clog2(CLKS_PER_UNIT + 1);
  localparam int NUM_T = 2;  // 0: per-packet, 1: absolute

  logic [NUM_T-1:0] expire;
  logic [DLY_W-1:0] delayVal [NUM_T];

  assign delayVal[0] = rxPktDelay;
  assign delayVal[1] = rxAbsDelay;

  generate
    for (genvar i = 0; i < NUM_T; i++) begin : g_tmr
      logic [CNT_W-1:0] loadVal;
      assign loadVal = CNT_W'(delayVal[i]) * CNT_W'(CLKS_PER_UNIT);
      nic_irq_countdown #(.CNT_W(CNT_W), .RESTART(i == 0)) u_cnt (
        .clk(clk), .rstN(rstN),
        .startReq(pktDoneIn && delayVal[i] != '0),
        .loadVal(loadVal), .expire(expire[i]));
    end
  endgenerate

  logic bothZero;
  assign bothZero = (rxPktDelay == '0) && (rxAbsDelay == '0);
  assign rxtPost  = (|expire) | (pktDoneIn & bothZero);

  AST_BOTH_ZERO_POST: assert property (@(posedge clk) disable iff (!rstN)
    pktDoneIn && bothZero |-> rxtPost); // R11
endmodule

// File: rtl/nic_irq_datapath.sv
module nic_irq_datapath
  import nic_irq_pkg::*;
#(
  parameter int CAUSE_W    = 8,
  parameter int ITR_W      = 16,
  parameter int TIME_W     = 32,
  parameter int NS_PER_CLK = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        str,
  input  logic [CAUSE_W-1:0] postBits,
  input  logic [ITR_W-1:0]   itrInterval,
  output logic [CAUSE_W-1:0] causeQ,
  output logic               ready,
  output logic               irqLatch
);
  localparam int PAD_W = TIME_W - ITR_W - 8;

  logic [TIME_W-1:0] nowNs, lastNs, elapsed, intervalNs;
  logic              stale;  // elapsed has grown past half the counter range

  assign elapsed    = nowNs - lastNs;
  assign intervalNs = {{PAD_W{1'b0}}, itrInterval, 8'h00};
  assign ready      = stale | (elapsed >= intervalNs);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowNs    <= '0;
      lastNs   <= '0;
      stale    <= 1'b0;
      causeQ   <= '0;
      irqLatch <= 1'b0;
    end else begin
      nowNs  <= nowNs + TIME_W'(NS_PER_CLK);
      causeQ <= str.clearCause ? postBits : (causeQ | postBits);
      if (str.deliver) begin
        lastNs   <= nowNs;
        stale    <= 1'b0;
        irqLatch <= 1'b1;
      end else begin
        if (elapsed[TIME_W-1]) stale <= 1'b1;
        if (str.dropLine) irqLatch <= 1'b0;
      end
    end
  end

  AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !str.clearCause |=> (causeQ & $past(causeQ)) == $past(causeQ)); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    str.clearCause && postBits == '0 |=> causeQ == '0); // R2
  AST_STAMP_ON_DELIVERY: assert property (@(posedge clk) disable iff (!rstN)
    str.deliver |=> lastNs == $past(nowNs)); // R6
endmodule

// File: rtl/nic_irq_control.sv
module nic_irq_control
  import nic_irq_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CAUSE_W-1:0] postBits,
  input  logic [CAUSE_W-1:0] causeQ,
  input  logic [CAUSE_W-1:0] causeMask,
  input  logic               causeRdIn,
  input  logic               urgentIn,
  input  logic               itrZero,
  input  logic               ready,
  output irqStrobes_t        str
);
  logic armed, postAny, effPend, immediate, deliverNow, deferFire, armReq, disarmReq;
  logic [CAUSE_W-1:0] effCause;

  assign postAny    = |(postBits & causeMask);
  assign effCause   = causeRdIn ? postBits : (causeQ | postBits);
  assign effPend    = |(effCause & causeMask);
  assign immediate  = itrZero | urgentIn | ready;
  assign deliverNow = postAny & immediate;
  assign deferFire  = armed & ready & effPend;
  assign armReq     = postAny & ~immediate & ~armed;
  assign disarmReq  = armed & ready & ~effPend;

  always_comb begin
    str.deliver    = deliverNow | deferFire;
    str.clearCause = causeRdIn;
    str.dropLine   = causeRdIn & ~str.deliver;
  end

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else if (str.deliver || disarmReq) armed <= 1'b0;
    else if (armReq) armed <= 1'b1;
  end

  AST_ITR_ZERO_NOW: assert property (@(posedge clk) disable iff (!rstN)
    itrZero && postAny |-> str.deliver); // R4
  AST_URGENT_NOW: assert property (@(posedge clk) disable iff (!rstN)
    urgentIn && postAny |-> str.deliver); // R5
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    !ready && !itrZero && !(urgentIn && postAny) |-> !str.deliver); // R7
  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    armed && !ready && !str.deliver |=> armed); // R7
  AST_DELIVER_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    str.deliver |=> !armed); // R8
endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator
  import nic_irq_pkg::*;
#(
  parameter int CAUSE_W     = 8,
  parameter int RXT_BIT     = 7,
  parameter int ITR_W       = 16,
  parameter int DLY_W       = 16,
  parameter int TIME_W      = 32,
  parameter int NS_PER_CLK  = 10,
  parameter int DLY_UNIT_NS = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CAUSE_W-1:0] causeIn,
  input  logic               urgentIn,
  input  logic               pktDoneIn,
  input  logic [CAUSE_W-1:0] causeMask,
  input  logic [ITR_W-1:0]   itrInterval,
  input  logic [DLY_W-1:0]   rxPktDelay,
  input  logic [DLY_W-1:0]   rxAbsDelay,
  input  logic               causeRdIn,
  output logic [CAUSE_W-1:0] causeRdData,
  output logic               irqOut
);
  localparam int CLKS_PER_UNIT = DLY_UNIT_NS / NS_PER_CLK;

  irqStrobes_t        str;
  logic               rxtPost, ready, irqLatch;
  logic [CAUSE_W-1:0] postBits, causeQ;

  nic_irq_rx_timers #(.DLY_W(DLY_W), .CLKS_PER_UNIT(CLKS_PER_UNIT)) u_timers (
    .clk(clk), .rstN(rstN), .pktDoneIn(pktDoneIn),
    .rxPktDelay(rxPktDelay), .rxAbsDelay(rxAbsDelay), .rxtPost(rxtPost));

  assign postBits = causeIn | (CAUSE_W'(rxtPost) << RXT_BIT);

  nic_irq_control #(.CAUSE_W(CAUSE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .postBits(postBits), .causeQ(causeQ),
    .causeMask(causeMask), .causeRdIn(causeRdIn), .urgentIn(urgentIn),
    .itrZero(itrInterval == '0), .ready(ready), .str(str));

  nic_irq_datapath #(.CAUSE_W(CAUSE_W), .ITR_W(ITR_W), .TIME_W(TIME_W),
                     .NS_PER_CLK(NS_PER_CLK)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .postBits(postBits),
    .itrInterval(itrInterval), .causeQ(causeQ), .ready(ready), .irqLatch(irqLatch));

  assign causeRdData = causeQ;
  assign irqOut      = irqLatch & |(causeQ & causeMask);
endmodule

// File: tb/nic_irq_moderator_bench.sv
module nic_irq_moderator_bench;
  localparam int CW = 8, RXT = 7, NSPC = 10, UNIT = 100;

  logic clk = 1'b0, rstN = 1'b0;
  logic [CW-1:0] causeIn = '0, causeMask = '1, causeRdData;
  logic urgentIn = 0, pktDoneIn = 0, causeRdIn = 0, irqOut;
  logic [15:0] itrInterval = '0, rxPktDelay = '0, rxAbsDelay = '0;

  always #5 clk = ~clk;

  nic_irq_moderator u_nic_irq_moderator (
    .clk(clk), .rstN(rstN), .causeIn(causeIn), .urgentIn(urgentIn),
    .pktDoneIn(pktDoneIn), .causeMask(causeMask), .itrInterval(itrInterval),
    .rxPktDelay(rxPktDelay), .rxAbsDelay(rxAbsDelay), .causeRdIn(causeRdIn),
    .causeRdData(causeRdData), .irqOut(irqOut));

  int nChecks = 0, nFails = 0;
  // reference model state
  longint mNow = 0, mLast = 0;
  int mPkt = 0, mAbs = 0;
  logic [CW-1:0] mCause = '0;
  bit mLatch = 0, mArmed = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit rxt, postAny, ready, immediate, deliver, effPend;
    logic [CW-1:0] post, eff;
    rxt = (mPkt == 1) || (mAbs == 1) || (pktDoneIn && rxPktDelay == 0 && rxAbsDelay == 0);
    post = causeIn | (CW'(rxt) << RXT);
    postAny = |(post & causeMask);
    ready = (mNow - mLast) >= longint'(itrInterval) * 256;
    immediate = (itrInterval == 0) || urgentIn || ready;
    eff = causeRdIn ? post : (mCause | post);
    effPend = |(eff & causeMask);
    deliver = (postAny && immediate) || (mArmed && ready && effPend);
    if (deliver) mArmed = 0;
    else if (postAny && !immediate) mArmed = 1;
    else if (mArmed && ready) mArmed = 0;
    if (deliver) begin mLatch = 1; mLast = mNow; end
    else if (causeRdIn) mLatch = 0;
    mCause = eff;
    if (pktDoneIn && rxPktDelay != 0) mPkt = rxPktDelay * UNIT;
    else if (mPkt != 0) mPkt--;
    if (pktDoneIn && rxAbsDelay != 0 && mAbs == 0) mAbs = rxAbsDelay * UNIT;
    else if (mAbs != 0) mAbs--;
    mNow += NSPC;
  endtask

  // one clock: edge, then compare against the model away from the edge
  task automatic tick();
    bit expIrq;
    @(posedge clk);
    #2;
    modelStep();
    expIrq = mLatch && |(mCause & causeMask);
    check(irqOut == expIrq, "R3 irq line vs model", irqOut, expIrq);
    check(causeRdData == mCause, "R1 cause register vs model", causeRdData, mCause);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(input logic [CW-1:0] c, input bit urg);
    causeIn = c; urgentIn = urg; tick(); causeIn = '0; urgentIn = 0;
  endtask

  task automatic readClear();
    causeRdIn = 1; tick(); causeRdIn = 0;
  endtask

  // ticks from an urgent delivery until a following early cause fires
  task automatic measureDefer(input string tag, input int expTicks);
    int n;
    pulse(8'h02, 1);                       // urgent: delivered now
    check(irqOut == 1, {tag, " urgent delivery"}, irqOut, 1);
    readClear(); n = 1;                    // R8: any old deferral is gone
    pulse(8'h01, 0); n++;                  // early: arms
    check(irqOut == 0, {tag, " early cause held"}, irqOut, 0);
    for (int i = 0; i < 9; i++) begin tick(); n++; end
    pulse(8'h04, 0); n++;                  // must not push the deferral
    while (!irqOut && n < 300) begin tick(); n++; end
    check(n == expTicks, {tag, " deferred fire tick"}, n, expTicks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check(irqOut == 0, "R3 reset line low", irqOut, 0);
    check(causeRdData == 0, "R1 reset cause clear", causeRdData, 0);
    rstN = 1;

    // R4: zero interval, immediate; R1 sticky OR
    pulse(8'h01, 0);
    check(irqOut == 1, "R4 immediate with zero interval", irqOut, 1);
    pulse(8'h04, 0);
    check(causeRdData == 8'h05, "R1 sticky OR", causeRdData, 8'h05);
    causeRdIn = 1; #1;
    check(causeRdData == 8'h05, "R2 read returns contents", causeRdData, 8'h05);
    tick(); causeRdIn = 0;
    check(causeRdData == 0 && irqOut == 0, "R2 read clears and drops line", irqOut, 0);

    // R2: read and new cause in the same cycle
    pulse(8'h08, 0);
    causeRdIn = 1; causeIn = 8'h10; tick(); causeRdIn = 0; causeIn = '0;
    check(causeRdData == 8'h10, "R2 same-cycle post survives read", causeRdData, 8'h10);
    readClear();

    // R3: masked cause never delivers
    causeMask = 8'h0F; pulse(8'h10, 0);
    check(irqOut == 0, "R3 masked cause no line", irqOut, 0);
    check(causeRdData == 8'h10, "R1 masked cause still latched", causeRdData, 8'h10);
    readClear(); causeMask = '1;

    // R7/R5: interval 3 = 768 ns = 77 clocks from the urgent delivery
    itrInterval = 16'd3;
    measureDefer("R7", 77);
    // R8: repeat from a fresh urgent delivery; spacing restarts from it
    readClear();
    pulse(8'h01, 0);                       // arms against the last delivery
    measureDefer("R8", 77);

    // R6: spacing already elapsed -> immediate
    readClear(); itrInterval = 16'd1; idle(30);
    pulse(8'h01, 0);
    check(irqOut == 1, "R6 elapsed spacing immediate", irqOut, 1);
    readClear();

    // R11: both delays zero
    itrInterval = 0; pktDoneIn = 1; tick(); pktDoneIn = 0;
    check(causeRdData[RXT] == 1 && irqOut == 1, "R11 immediate receive cause", causeRdData, 8'h80);
    readClear();

    // R9: absolute timer, second completion does not restart it
    rxAbsDelay = 1; pktDoneIn = 1; tick(); pktDoneIn = 0; n = 0;
    for (int i = 0; i < 49; i++) begin tick(); n++; end
    pktDoneIn = 1; tick(); pktDoneIn = 0; n++;
    while (!causeRdData[RXT] && n < 400) begin tick(); n++; end
    check(n == 100, "R9 absolute timer expiry", n, 100);
    readClear(); rxAbsDelay = 0; idle(3);

    // R10: per-packet timer restarts on each completion
    rxPktDelay = 1; pktDoneIn = 1; tick(); pktDoneIn = 0; n = 0;
    for (int i = 0; i < 49; i++) begin tick(); n++; end
    pktDoneIn = 1; tick(); pktDoneIn = 0; n++;
    while (!causeRdData[RXT] && n < 400) begin tick(); n++; end
    check(n == 150, "R10 per-packet timer restart", n, 150);
    readClear(); rxPktDelay = 0;

    // R12: timer-posted cause obeys the throttle
    itrInterval = 16'd3; pulse(8'h02, 1); readClear();
    pktDoneIn = 1; tick(); pktDoneIn = 0;
    check(irqOut == 0 && causeRdData[RXT] == 1, "R12 receive cause throttled", irqOut, 0);
    idle(90);
    check(irqOut == 1, "R12 receive cause delivered later", irqOut, 1);
    readClear();

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      causeIn    = ($urandom % 6 == 0) ? CW'($urandom) : '0;
      urgentIn   = ($urandom % 10 == 0);
      pktDoneIn  = ($urandom % 25 == 0);
      causeRdIn  = ($urandom % 12 == 0);
      if ($urandom % 400 == 0) begin
        itrInterval = 16'($urandom % 4);
        rxPktDelay  = 16'($urandom % 3);
        rxAbsDelay  = 16'($urandom % 3);
        causeMask   = ($urandom % 2) ? '1 : CW'($urandom);
      end
      tick();
    end
    causeIn = '0; urgentIn = 0; pktDoneIn = 0; causeRdIn = 0;
    idle(5);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule